// File: doc/BRIEF.md
# Direction-Locking Open-Drain Repeater

This block joins two segments (side A and side B) of a two-wire open-drain bus, one channel for the clock line and one for the data line. Each side is seen as a sampled level input plus a pull-low enable output that drives an external open-drain transistor. When an outside device pulls one side low, the repeater pulls the other side low, and it keeps doing so until that outside device lets go.

Each channel locks its direction when it sees the first low. The low that the repeater itself creates on the far side is never sent back, so the two sides cannot hold each other low forever. When the active side is released, the far pull-low is dropped. The direction then stays locked for a set number of cycles, so that the driven side can rise and pass through the synchronizer before it is sampled again. A connect enable from a supervisor gates all forwarding. With the enable low, the two segments are isolated.

Top module: `lockdir_repeater`

## Requirements
- R1: A low on side A of an idle, enabled channel sets that channel's B pull-low on the third rising clock edge after the change at the pin, through a two-stage synchronizer plus one state register. The channel's status then reads 2'b01 (A to B). The status encoding is 2'b00 idle, 2'b01 A to B, 2'b10 B to A. Channel 0 is the clock line and channel 1 is the data line, and each channel owns bits [2i+1:2i] of the status.
- R2: A low on side B of an idle, enabled channel sets that channel's A pull-low with the same three-edge latency, and the status reads 2'b10.
- R3: While a direction is active, the far-side pull-low holds for as long as the active side stays low. The low that this pull creates on the driven side is never forwarded back, so both pull-lows of a channel are never set together.
- R4: The far-side pull-low clears on the third edge after the active side returns high. The status keeps the locked direction for HOLD_CYCLES more edges and then reads 2'b00. Lows seen on either side during this hold are ignored.
- R5: If both sides of an idle channel are seen low in the same sample cycle, side A wins: B is pulled low and the status reads 2'b01.
- R6: The channels are independent. One channel can forward A to B while the other forwards B to A at the same time.
- R7: While the connect enable is low, no low is forwarded in either direction. An active channel releases both pull-lows by the next edge and returns to idle.
- R8: If an outside device keeps the driven side low after the active side has released (clock stretching), that low is forwarded to the other side once the hold ends.
- R9: After reset, all pull-lows are clear and every status reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| connect_en | input | 1 | Supervisor permission to forward |
| a_in | input | NUM_CH | Sampled line level on side A, one bit per channel |
| b_in | input | NUM_CH | Sampled line level on side B, one bit per channel |
| a_pull | output | NUM_CH | Pull-low enable for side A |
| b_pull | output | NUM_CH | Pull-low enable for side B |
| dir_status | output | 2*NUM_CH | Direction of each channel, two bits per channel |

## Verification
The assertions check four rules on every cycle. No channel pulls both of its sides low. A pull-low always matches the direction its status reports, and a direction is only ever taken from idle. Dropping the enable clears every pull on the next edge. A far-side pull may only fall after the active input has been high long enough to pass the synchronizer. The bench scenarios show the rest: the exact three-edge latencies, the length of the hold window, the A-wins tie rule, simultaneous opposite directions on the two channels, and a stretched low being carried back after the hold. For these, the bench models the wired bus so that the repeater sees its own pulls on the far side.

// File: rtl/lockdir_pkg.sv
`timescale 1ns/1ps
package lockdir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'b00,
    DIR_A2B  = 2'b01,
    DIR_B2A  = 2'b10
  } dir_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_FWD_AB   = 3'd1,
    ST_FWD_BA   = 3'd2,
    ST_HOLD_AB  = 3'd3,
    ST_HOLD_BA  = 3'd4
  } chan_st_t;
endpackage

// File: rtl/lockdir_sync.sv
`timescale 1ns/1ps
module lockdir_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  // idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '1;
    else        chain_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '1;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/lockdir_chan.sv
`timescale 1ns/1ps
module lockdir_chan
  import lockdir_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       a_low,
  input  logic       b_low,
  output logic       a_pull,
  output logic       b_pull,
  output logic [1:0] status
);
  chan_st_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en && a_low)      state_d = ST_FWD_AB;   // side A wins a tie
        else if (en && b_low) state_d = ST_FWD_BA;
      end
      ST_FWD_AB: begin
        if (!en) state_d = ST_IDLE;
        else if (!a_low) begin
          state_d = ST_HOLD_AB;
          cnt_d   = CW'(HOLD_CYCLES - 1);
          cnt_en  = 1'b1;
        end
      end
      ST_FWD_BA: begin
        if (!en) state_d = ST_IDLE;
        else if (!b_low) begin
          state_d = ST_HOLD_BA;
          cnt_d   = CW'(HOLD_CYCLES - 1);
          cnt_en  = 1'b1;
        end
      end
      ST_HOLD_AB, ST_HOLD_BA: begin
        if (!en || cnt_q == '0) state_d = ST_IDLE;
        else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign b_pull = (state_q == ST_FWD_AB);
  assign a_pull = (state_q == ST_FWD_BA);

  always_comb begin
    unique case (state_q)
      ST_FWD_AB, ST_HOLD_AB: status = DIR_A2B;
      ST_FWD_BA, ST_HOLD_BA: status = DIR_B2A;
      default:               status = DIR_IDLE;
    endcase
  end
endmodule

// File: rtl/lockdir_repeater.sv
`timescale 1ns/1ps
module lockdir_repeater #(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  localparam int SW = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              connect_en,
  input  logic [NUM_CH-1:0] a_in,
  input  logic [NUM_CH-1:0] b_in,
  output logic [NUM_CH-1:0] a_pull,
  output logic [NUM_CH-1:0] b_pull,
  output logic [SW-1:0]     dir_status
);
  logic [NUM_CH-1:0] a_s, b_s;

  lockdir_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({b_in, a_in}),
    .d_out ({b_s, a_s})
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    lockdir_chan #(.HOLD_CYCLES(HOLD_CYCLES)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (connect_en),
      .a_low  (~a_s[i]),
      .b_low  (~b_s[i]),
      .a_pull (a_pull[i]),
      .b_pull (b_pull[i]),
      .status (dir_status[2*i +: 2])
    );
  end
endmodule

// File: rtl/lockdir_checker.sv
`timescale 1ns/1ps
module lockdir_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              connect_en,
  input logic [NUM_CH-1:0] a_in,
  input logic [NUM_CH-1:0] b_in,
  input logic [NUM_CH-1:0] a_pull,
  input logic [NUM_CH-1:0] b_pull,
  input logic [2*NUM_CH-1:0] dir_status
);
  a_r7_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    !connect_en |=> (a_pull == '0 && b_pull == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r3_single_dir: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_pull[i] && b_pull[i]));

    a_r1_pull_matches_dir: assert property (@(posedge clk) disable iff (!rst_n)
      b_pull[i] |-> dir_status[2*i +: 2] == 2'b01);

    a_r2_pull_matches_dir: assert property (@(posedge clk) disable iff (!rst_n)
      a_pull[i] |-> dir_status[2*i +: 2] == 2'b10);

    a_r4_lock_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_pull[i] | a_pull[i]) |-> $past(dir_status[2*i +: 2]) == 2'b00);

    a_r4_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(b_pull[i]) && $past(connect_en)) |-> $past(a_in[i], 3));
  end
endmodule

bind lockdir_repeater lockdir_checker #(.NUM_CH(NUM_CH)) u_lockdir_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .connect_en (connect_en),
  .a_in       (a_in),
  .b_in       (b_in),
  .a_pull     (a_pull),
  .b_pull     (b_pull),
  .dir_status (dir_status)
);

// File: tb/lockdir_repeater_bench.sv
`timescale 1ns/1ps
module lockdir_repeater_bench;
  localparam int NCH  = 2;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic connect_en;
  logic [NCH-1:0] a_ext, b_ext;   // 1 = outside device pulls that side low
  logic [NCH-1:0] a_in, b_in, a_pull, b_pull;
  logic [2*NCH-1:0] dir_status;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-AND bus model: each side sees every pull on it
  assign a_in = ~(a_ext | a_pull);
  assign b_in = ~(b_ext | b_pull);

  lockdir_repeater #(.NUM_CH(NCH), .SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) u_lockdir_repeater (
    .clk(clk), .rst_n(rst_n), .connect_en(connect_en),
    .a_in(a_in), .b_in(b_in), .a_pull(a_pull), .b_pull(b_pull),
    .dir_status(dir_status)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int st(input int ch);
    return int'(dir_status[2*ch +: 2]);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; connect_en = 1'b1; a_ext = '0; b_ext = '0;
    wait_neg(3);
    chk("R9", "a_pull after reset", int'(a_pull), 0);
    chk("R9", "b_pull after reset", int'(b_pull), 0);
    chk("R9", "status after reset", int'(dir_status), 0);
    rst_n = 1'b1;
    wait_neg(4);
  endtask

  task automatic t_a_to_b();
    a_ext[0] = 1'b1;
    wait_neg(2);
    chk("R1", "b_pull before third edge", int'(b_pull[0]), 0);
    wait_neg(1);
    chk("R1", "b_pull on third edge", int'(b_pull[0]), 1);
    chk("R1", "status A2B", st(0), 1);
    chk("R1", "side B line low", int'(b_in[0]), 0);
    wait_neg(6);
    chk("R3", "no pull back onto A", int'(a_pull[0]), 0);
    chk("R3", "b_pull held", int'(b_pull[0]), 1);
    a_ext[0] = 1'b0;
    wait_neg(2);
    chk("R4", "b_pull before release edge", int'(b_pull[0]), 1);
    wait_neg(1);
    chk("R4", "b_pull released", int'(b_pull[0]), 0);
    wait_neg(HOLD - 1);
    chk("R4", "status still locked", st(0), 1);
    chk("R4", "feedback low ignored in hold", int'(a_pull[0]), 0);
    wait_neg(1);
    chk("R4", "status idle after hold", st(0), 0);
    wait_neg(4);
    chk("R4", "stays idle", st(0), 0);
  endtask

  task automatic t_b_to_a();
    b_ext[1] = 1'b1;
    wait_neg(2);
    chk("R2", "a_pull before third edge", int'(a_pull[1]), 0);
    wait_neg(1);
    chk("R2", "a_pull on third edge", int'(a_pull[1]), 1);
    chk("R2", "status B2A", st(1), 2);
    chk("R3", "no pull back onto B", int'(b_pull[1]), 0);
    b_ext[1] = 1'b0;
    wait_neg(3);
    chk("R4", "a_pull released", int'(a_pull[1]), 0);
    wait_neg(HOLD + 4);
    chk("R4", "status idle", st(1), 0);
  endtask

  task automatic t_tie();
    a_ext[0] = 1'b1; b_ext[0] = 1'b1;
    wait_neg(3);
    chk("R5", "tie status A2B", st(0), 1);
    chk("R5", "tie b_pull", int'(b_pull[0]), 1);
    chk("R5", "tie a_pull", int'(a_pull[0]), 0);
    a_ext[0] = 1'b0; b_ext[0] = 1'b0;
    wait_neg(HOLD + 8);
    chk("R5", "idle after tie", int'(dir_status), 0);
  endtask

  task automatic t_indep();
    a_ext[0] = 1'b1; b_ext[1] = 1'b1;
    wait_neg(3);
    chk("R6", "ch0 status A2B", st(0), 1);
    chk("R6", "ch1 status B2A", st(1), 2);
    chk("R6", "pulls b", int'(b_pull), 1);
    chk("R6", "pulls a", int'(a_pull), 2);
    a_ext[0] = 1'b0; b_ext[1] = 1'b0;
    wait_neg(HOLD + 8);
    chk("R6", "both idle", int'(dir_status), 0);
  endtask

  task automatic t_isolate();
    connect_en = 1'b0;
    a_ext[1] = 1'b1;
    wait_neg(8);
    chk("R7", "no forward while disabled", int'(b_pull[1]), 0);
    chk("R7", "status idle while disabled", st(1), 0);
    connect_en = 1'b1;
    wait_neg(1);
    chk("R7", "forward once enabled", int'(b_pull[1]), 1);
    connect_en = 1'b0;
    wait_neg(1);
    chk("R7", "pull released on disable", int'(b_pull[1]), 0);
    chk("R7", "idle on disable", st(1), 0);
    a_ext[1] = 1'b0;
    wait_neg(6);
    connect_en = 1'b1;
    wait_neg(6);
    chk("R7", "idle after re-enable", int'(dir_status), 0);
  endtask

  task automatic t_stretch();
    a_ext[0] = 1'b1;
    wait_neg(5);
    b_ext[0] = 1'b1;   // a device on B stretches the low
    wait_neg(2);
    a_ext[0] = 1'b0;
    wait_neg(3 + HOLD + 4);
    chk("R8", "stretch forwarded to A", int'(a_pull[0]), 1);
    chk("R8", "status B2A", st(0), 2);
    chk("R8", "side A line low", int'(a_in[0]), 0);
    b_ext[0] = 1'b0;
    wait_neg(3 + HOLD + 4);
    chk("R8", "idle after stretch", int'(dir_status), 0);
    chk("R8", "lines high", int'({a_in, b_in}), 15);
  endtask

  initial begin
    t_reset();
    t_a_to_b();
    t_b_to_a();
    t_tie();
    t_indep();
    t_isolate();
    t_stretch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule